// File: doc/BRIEF.md
# Byte-Lane Static Memory With Mode Decode

This block is a clocked, synthesizable stand-in for a 16-bit word-addressed static memory. It keeps the control pins of an asynchronous part: an active-low select, an active-high select, an active-low write strobe, an active-low output enable and one active-low enable for each byte lane. The bidirectional data bus is split into a data input, a data output and a drive flag for each lane. An outside pad or bus model combines these into a real tristate bus. A driven-off lane carries zero on `data_out`.

On every rising edge the controls are decoded into one of four modes: standby, read, write or selected-but-quiet. A write stores only the enabled byte lanes of `data_in` at `addr`. A read returns the addressed word on the enabled lanes. The read result appears after `RD_LAT` rising edges, which models access time. The write strobe takes priority over the output enable, so no lane is driven during a write. Memory contents are not cleared by reset.

Top module: `lane_sram`

## Requirements
- R1: When `chip_sel_n` is 1 or `chip_sel` is 0, the block is in standby. No location is written and both `lane_drive` bits are 0 at the matching output time, whatever the other inputs are.
- R2: When selected (`chip_sel_n`=0, `chip_sel`=1) with `wr_strobe_n`=0, the enabled lanes of `data_in` are stored at `addr`. `out_en_n` has no effect on a write.
- R3: When selected with `wr_strobe_n`=1 and `out_en_n`=0, the stored word at `addr` is returned on the enabled lanes.
- R4: When selected with `wr_strobe_n`=1 and `out_en_n`=1, no lane is driven and no location is written.
- R5: `byte_lo_n`=0 enables bits 7:0 and `lane_drive[0]`. `byte_hi_n`=0 enables bits 15:8 and `lane_drive[1]`.
- R6: A write with a single byte enable active changes only that byte. The other byte of the word keeps its stored value.
- R7: On a single-byte read, the other lane has its `lane_drive` bit at 0 and its `data_out` bits at 0.
- R8: With `byte_lo_n`=1 and `byte_hi_n`=1, no location is written and both `lane_drive` bits are 0.
- R9: A read sampled on rising edge k shows its data and drive bits right after edge k+RD_LAT-1. The outputs before that edge still reflect the earlier cycle.
- R10: A write cycle gives `lane_drive`=0 on both lanes at its output time.
- R11: After reset, `lane_drive` is 0 and `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output pipeline |
| addr | input | ADDR_W | Word address |
| chip_sel_n | input | 1 | Active-low select |
| chip_sel | input | 1 | Active-high select |
| wr_strobe_n | input | 1 | Active-low write strobe |
| out_en_n | input | 1 | Active-low output enable |
| byte_lo_n | input | 1 | Active-low enable, bits 7:0 |
| byte_hi_n | input | 1 | Active-low enable, bits 15:8 |
| data_in | input | 16 | Write data |
| data_out | output | 16 | Read data, zero on lanes not driven |
| lane_drive | output | 2 | Per-lane drive flag, bit 0 low byte, bit 1 high byte |

## Verification
Full-word writes and reads at the lowest, highest and a mixed address show that the address decodes and that both lanes map to the right bits. Single-lane writes followed by full-word reads separate a masked write from a full one. Single-lane reads show whether the idle lane tristates on its own. Write attempts in standby (each select released in turn) and with both byte enables off are read back to prove that nothing was stored. A write issued with the output enable active tells apart a design where the write wins from one where the read path leaks. A peek one edge early pins down the read latency.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        MODE_STBY  = 2'd0,
        MODE_QUIET = 2'd1,
        MODE_RD    = 2'd2,
        MODE_WR    = 2'd3
    } mode_e;

    typedef struct packed {
        logic [LANES-1:0]  oe;
        logic [DATA_W-1:0] data;
    } stage_t;
endpackage

// File: rtl/lane_sram_decode.sv
module lane_sram_decode
    import lane_sram_pkg::*;
(
    input  logic             chip_sel_n,
    input  logic             chip_sel,
    input  logic             wr_strobe_n,
    input  logic             out_en_n,
    input  logic [LANES-1:0] lane_n,
    output mode_e            mode,
    output logic [LANES-1:0] wr_lane,
    output logic [LANES-1:0] rd_lane
);
    logic selected;

    always_comb begin
        selected = !chip_sel_n && chip_sel;
        if (!selected)         mode = MODE_STBY;
        else if (!wr_strobe_n) mode = MODE_WR;
        else if (!out_en_n)    mode = MODE_RD;
        else                   mode = MODE_QUIET;
        wr_lane = (mode == MODE_WR) ? ~lane_n : '0;
        rd_lane = (mode == MODE_RD) ? ~lane_n : '0;
    end

    always_comb begin
        if (mode == MODE_WR) begin
            AST_WR_NO_DRIVE: assert (rd_lane == '0); // R10
        end
    end
endmodule

// File: rtl/lane_sram_bank.sv
module lane_sram_bank
    import lane_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] wdata,
    output logic [LANE_W-1:0] rdata
);
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic [LANE_W-1:0] rd_d, rd_q;

    always_comb rd_d = mem_q[addr];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[addr] <= wdata;
        rd_q <= rd_d;
    end

    assign rdata = rd_q;

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(addr)] == $past(wdata)); // R2
    AST_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> mem_q[$past(addr)] == $past(mem_q[addr])); // R6
endmodule

// File: rtl/lane_sram_pipe.sv
module lane_sram_pipe
    import lane_sram_pkg::*;
#(
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_oe,
    input  logic [DATA_W-1:0] bank_rd,
    output logic [DATA_W-1:0] data_out,
    output logic [LANES-1:0]  lane_drive
);
    logic [LANES-1:0] oe_d, oe_q;
    stage_t head;

    always_comb oe_d = lane_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= '0;
        else        oe_q <= oe_d;
    end

    always_comb head.oe = oe_q;
    for (genvar g = 0; g < LANES; g++) begin : g_mask
        assign head.data[g*LANE_W +: LANE_W] =
            oe_q[g] ? bank_rd[g*LANE_W +: LANE_W] : '0;
    end

    if (RD_LAT <= 1) begin : g_short
        assign data_out   = head.data;
        assign lane_drive = head.oe;
    end else begin : g_long
        localparam int EXTRA = RD_LAT - 1;
        stage_t chain_d [EXTRA];
        stage_t chain_q [EXTRA];

        always_comb begin
            chain_d[0] = head;
            for (int i = 1; i < EXTRA; i++) chain_d[i] = chain_q[i-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < EXTRA; i++) chain_q[i] <= '0;
            end else begin
                for (int i = 0; i < EXTRA; i++) chain_q[i] <= chain_d[i];
            end
        end

        assign data_out   = chain_q[EXTRA-1].data;
        assign lane_drive = chain_q[EXTRA-1].oe;

        AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> chain_q[0].oe == $past(oe_q)); // R9
    end
endmodule

// File: rtl/lane_sram.sv
module lane_sram
    import lane_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip_sel_n,
    input  logic              chip_sel,
    input  logic              wr_strobe_n,
    input  logic              out_en_n,
    input  logic              byte_lo_n,
    input  logic              byte_hi_n,
    input  logic [15:0]       data_in,
    output logic [15:0]       data_out,
    output logic [1:0]        lane_drive
);
    mode_e             mode;
    logic [LANES-1:0]  wr_lane, rd_lane;
    logic [DATA_W-1:0] bank_rd;

    lane_sram_decode u_decode (
        .chip_sel_n  (chip_sel_n),
        .chip_sel    (chip_sel),
        .wr_strobe_n (wr_strobe_n),
        .out_en_n    (out_en_n),
        .lane_n      ({byte_hi_n, byte_lo_n}),
        .mode        (mode),
        .wr_lane     (wr_lane),
        .rd_lane     (rd_lane)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        lane_sram_bank #(.ADDR_W(ADDR_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_lane[g]),
            .addr  (addr),
            .wdata (data_in[g*LANE_W +: LANE_W]),
            .rdata (bank_rd[g*LANE_W +: LANE_W])
        );
    end

    lane_sram_pipe #(.RD_LAT(RD_LAT)) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_oe    (rd_lane),
        .bank_rd    (bank_rd),
        .data_out   (data_out),
        .lane_drive (lane_drive)
    );

    AST_STBY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel_n || !chip_sel) |-> (wr_lane == '0 && mode == MODE_STBY)); // R1
    AST_NO_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_lo_n && byte_hi_n) |-> (wr_lane == '0 && rd_lane == '0)); // R8
    AST_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_drive[0] |-> data_out[7:0] == 8'h00); // R7
    AST_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_drive[1] |-> data_out[15:8] == 8'h00); // R7
endmodule

// File: tb/lane_sram_tb.sv
module lane_sram_tb;
    localparam int AW  = 10;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          chip_sel_n = 1'b1, chip_sel = 1'b0;
    logic          wr_strobe_n = 1'b1, out_en_n = 1'b1;
    logic          byte_lo_n = 1'b1, byte_hi_n = 1'b1;
    logic [15:0]   data_in = '0;
    logic [15:0]   data_out;
    logic [1:0]    lane_drive;

    logic [15:0]   shadow [1 << AW];
    int            n_chk = 0, n_bad = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    lane_sram #(.ADDR_W(AW), .RD_LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .chip_sel_n(chip_sel_n), .chip_sel(chip_sel),
        .wr_strobe_n(wr_strobe_n), .out_en_n(out_en_n),
        .byte_lo_n(byte_lo_n), .byte_hi_n(byte_hi_n),
        .data_in(data_in), .data_out(data_out), .lane_drive(lane_drive)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic apply(logic [AW-1:0] a, logic csn, logic cs, logic wn,
                         logic oen, logic lon, logic hin, logic [15:0] d);
        addr = a; chip_sel_n = csn; chip_sel = cs; wr_strobe_n = wn;
        out_en_n = oen; byte_lo_n = lon; byte_hi_n = hin; data_in = d;
    endtask

    task automatic idle();
        apply('0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic do_write(logic [AW-1:0] a, logic [15:0] d, logic lon,
                            logic hin, logic oen);
        apply(a, 1'b0, 1'b1, 1'b0, oen, lon, hin, d);
        tick();
        if (!lon) shadow[a][7:0]  = d[7:0];
        if (!hin) shadow[a][15:8] = d[15:8];
        idle();
    endtask

    task automatic read_chk(string req, logic [AW-1:0] a, logic lon, logic hin);
        logic [15:0] exp_d;
        apply(a, 1'b0, 1'b1, 1'b1, 1'b0, lon, hin, 16'hDEAD);
        tick();
        idle();
        repeat (LAT - 1) tick();
        exp_d = shadow[a] & {{8{!hin}}, {8{!lon}}};
        check(req, {30'd0, lane_drive}, {30'd0, !hin, !lon});
        check(req, {16'd0, data_out}, {16'd0, exp_d});
    endtask

    task automatic t_reset();
        check("R11 drive", {30'd0, lane_drive}, 32'd0);
        check("R11 data", {16'd0, data_out}, 32'd0);
    endtask

    task automatic t_word();
        do_write(10'h000, 16'hA55A, 1'b0, 1'b0, 1'b1);
        do_write(10'h3FF, 16'h1234, 1'b0, 1'b0, 1'b0); // R2 oe ignored
        do_write(10'h155, 16'hC3F0, 1'b0, 1'b0, 1'b1);
        read_chk("R3 R5 low addr", 10'h000, 1'b0, 1'b0);
        read_chk("R2 R3 top addr", 10'h3FF, 1'b0, 1'b0);
        read_chk("R3 R5 mid addr", 10'h155, 1'b0, 1'b0);
    endtask

    task automatic t_latency();
        apply(10'h155, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        tick();
        idle();
        check("R9 early", {30'd0, lane_drive}, 32'd0);
        tick();
        check("R9 on time", {16'd0, data_out}, {16'd0, shadow[10'h155]});
        tick();
        check("R9 after", {30'd0, lane_drive}, 32'd0);
    endtask

    task automatic t_bytes();
        do_write(10'h020, 16'h1111, 1'b0, 1'b0, 1'b1);
        do_write(10'h020, 16'hEEAB, 1'b0, 1'b1, 1'b1);
        read_chk("R6 low only", 10'h020, 1'b0, 1'b0);
        check("R6 low word", {16'd0, shadow[10'h020]}, 32'h000011AB);
        do_write(10'h020, 16'h77CC, 1'b1, 1'b0, 1'b1);
        read_chk("R6 high only", 10'h020, 1'b0, 1'b0);
    endtask

    task automatic t_single_read();
        read_chk("R7 R5 low lane", 10'h020, 1'b0, 1'b1);
        read_chk("R7 R5 high lane", 10'h020, 1'b1, 1'b0);
    endtask

    task automatic t_standby();
        apply(10'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF);
        tick();
        apply(10'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF);
        tick();
        apply(10'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0);
        tick();
        idle();
        repeat (LAT - 1) tick();
        check("R1 read off", {30'd0, lane_drive}, 32'd0);
        read_chk("R1 no write", 10'h000, 1'b0, 1'b0);
    endtask

    task automatic t_quiet();
        apply(10'h3FF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hBEEF);
        tick();
        idle();
        repeat (LAT - 1) tick();
        check("R4 no drive", {30'd0, lane_drive}, 32'd0);
        read_chk("R4 no write", 10'h3FF, 1'b0, 1'b0);
    endtask

    task automatic t_no_lanes();
        apply(10'h155, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0F0F);
        tick();
        idle();
        read_chk("R8 read none", 10'h155, 1'b1, 1'b1);
        read_chk("R8 no write", 10'h155, 1'b0, 1'b0);
    endtask

    task automatic t_write_drive();
        apply(10'h040, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h5AA5);
        tick();
        shadow[10'h040] = 16'h5AA5;
        idle();
        repeat (LAT - 1) tick();
        check("R10 drive", {30'd0, lane_drive}, 32'd0);
        read_chk("R10 stored", 10'h040, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_word();
        t_latency();
        t_bytes();
        t_single_read();
        t_standby();
        t_quiet();
        t_no_lanes();
        t_write_drive();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule